// File: doc/BRIEF.md
# SMBus Register Target with Alert Response

This block is a bus target for a two-wire SMBus/I2C link. It samples SCL and SDA on the system clock and pulls SDA low through an open-drain enable; it never drives SCL. A small bank of 8-bit registers sits behind a single register pointer. A controller can reach the bank with four transactions. Write Byte sends the pointer and then one data byte. Read Byte sends the pointer and then issues a repeated start with a read. Receive Byte is a read with no pointer phase. Read Word is a read in which the controller acknowledges the first byte.

The pointer is not cleared at STOP, so a Receive Byte keeps returning the last register that was selected. A read never advances the pointer, and a second byte in the same read returns the same register again. The block also answers the SMBus Alert Response Address, but only while the surrounding alert logic reports a pending alert. It then sends its own 7-bit address on a wired-AND bus, so the lowest address wins. It drops out as soon as it loses a bit.

Two one-cycle pulses go back to the alert logic. One marks a won arbitration. The other marks a transaction that named this target's own address. Either pulse tells the alert logic to release its line.

Top module: `smbus_alert_target`

## Requirements
- R1: After reset, SDA is released, both pulse outputs are low, the pointer is 0, and register i holds 8'hA0 OR i.
- R2: An address byte whose first 7 bits (MSB first) equal OWN_ADDR (default 7'h2A) is acknowledged by pulling SDA low during the 9th clock. The 8th bit is R/W, where 1 means read.
- R3: After a write address, the first data byte loads the pointer and a second data byte is stored into the register the pointer selects. Each of these bytes is acknowledged.
- R4: The pointer survives STOP, so a read with no pointer phase returns the register selected last. Repeating that read returns the same value again.
- R5: A read returns the selected register MSB first, also after a repeated start that follows a pointer write. When the controller ACKs a byte, the same register is sent again. After a NACK, SDA stays released until STOP or START.
- R6: An address byte that matches neither OWN_ADDR nor the alert response address gets no acknowledge and no pulse.
- R7: The alert response address 7'b0001100 is acknowledged only with R/W=1 and only while alertActive is high. Otherwise it is not acknowledged.
- R8: The alert response byte is OWN_ADDR followed by a 1, sent MSB first. When all 8 bits complete without a loss, arbWon pulses for one cycle.
- R9: If the target sends a 1 but samples 0 during the alert response, it releases SDA for the rest of the transaction and arbWon does not pulse.
- R10: selfAddressed pulses for one cycle on each own-address match, for both read and write. It does not pulse for the alert response address.
- R11: Only the low PTR_W bits (2 by default) of the pointer byte select a register. The upper bits are ignored.
- R12: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL level seen on the pad |
| sdaIn | input | 1 | SDA level seen on the pad |
| sdaPullLow | output | 1 | 1 pulls SDA low; 0 releases it |
| alertActive | input | 1 | Alert pending from the alert logic |
| arbWon | output | 1 | One-cycle pulse: alert response sent without a loss |
| selfAddressed | output | 1 | One-cycle pulse: own address matched |

## Verification
Every bus edge reaches the control logic 2 + FILT_LEN system clocks after it happens on the pad. The target's acknowledge or data bit therefore appears a few clocks after each SCL fall. The bench drives SCL in quarter-periods of 10 clocks and samples SDA one quarter after SCL rises, which is well after that latency and well before the next fall. The arbWon and selfAddressed pulses come one clock after the deciding SCL edge is detected. They are counted as they occur, and the counts are compared only after the following STOP. Bytes read back go through a scoreboard queue loaded before each read. A change of the SDA drive while SCL is high is flagged on any clock.

// File: rtl/smbus_tgt_pkg.sv
package smbus_tgt_pkg;

  localparam logic [6:0] ALERT_RESP_ADDR = 7'b0001100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX_ADDR,
    ST_RX_DATA,
    ST_ACK_PEND,
    ST_ACK_DRIVE,
    ST_TX_BYTE,
    ST_MACK,
    ST_WAIT_END
  } tgtStateT;

  // Strobes from control to datapath
  typedef struct packed {
    logic bitClr;
    logic rxShift;
    logic txShift;
    logic txLoadReg;
    logic txLoadAra;
    logic ptrLoad;
    logic regLoad;
  } dpCtrlT;

endpackage

// File: rtl/smbus_tgt_pins.sv
module smbus_tgt_pins #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLevel,
  output logic sdaBit,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [1:0] rawIn;
  logic [1:0] filtV;
  logic [1:0] prevV;

  assign rawIn = {sdaIn, sclIn};

  // index 0 = SCL, index 1 = SDA
  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [1:0]       syncQ;
    logic [CNT_W-1:0] cnt;
    logic             filtQ;
    logic             prevQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= 2'b11;
        cnt   <= '0;
        filtQ <= 1'b1;
        prevQ <= 1'b1;
      end else begin
        syncQ <= {syncQ[0], rawIn[g]};
        prevQ <= filtQ;
        if (syncQ[1] == filtQ) begin
          cnt <= '0;
        end else if (cnt == CNT_W'(FILT_LEN - 1)) begin
          filtQ <= syncQ[1];
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    assign filtV[g] = filtQ;
    assign prevV[g] = prevQ;
  end

  assign sclLevel = filtV[0];
  assign sdaBit   = filtV[1];
  assign sclRise  = filtV[0] & ~prevV[0];
  assign sclFall  = ~filtV[0] & prevV[0];
  assign startDet = prevV[1] & ~filtV[1] & filtV[0] & prevV[0];
  assign stopDet  = ~prevV[1] & filtV[1] & filtV[0] & prevV[0];

endmodule

// File: rtl/smbus_tgt_dp.sv
module smbus_tgt_dp
  import smbus_tgt_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h2A,
  parameter int         PTR_W    = 2,
  parameter logic [7:0] RST_BASE = 8'hA0
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCtrlT     dpCtl,
  input  logic       sdaBit,
  output logic [6:0] rxLow7,
  output logic       bitLast,
  output logic       txBit
);

  localparam int NUM_REGS = 1 << PTR_W;

  logic [2:0]       bitCnt;
  logic [7:0]       rxSr;
  logic [7:0]       txSr;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       regs [NUM_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxSr   <= '0;
      txSr   <= '0;
      ptr    <= '0;
    end else begin
      if (dpCtl.bitClr)                       bitCnt <= '0;
      else if (dpCtl.rxShift || dpCtl.txShift) bitCnt <= bitCnt + 1'b1;

      if (dpCtl.rxShift) rxSr <= {rxSr[6:0], sdaBit};

      if (dpCtl.txLoadAra)      txSr <= {OWN_ADDR, 1'b1};
      else if (dpCtl.txLoadReg) txSr <= regs[ptr];
      else if (dpCtl.txShift)   txSr <= {txSr[6:0], 1'b1};

      if (dpCtl.ptrLoad) ptr <= rxSr[PTR_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   regs[i] <= RST_BASE | 8'(i);
      else if (dpCtl.regLoad && ptr == PTR_W'(i))  regs[i] <= rxSr;
    end

    p_reg_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
      !(dpCtl.regLoad && ptr == PTR_W'(i)) |=> $stable(regs[i]));
  end

  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtl.ptrLoad |=> $stable(ptr));

  assign rxLow7  = rxSr[6:0];
  assign bitLast = (bitCnt == 3'd7);
  assign txBit   = txSr[7];

endmodule

// File: rtl/smbus_tgt_ctrl.sv
module smbus_tgt_ctrl
  import smbus_tgt_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h2A
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       sclLevel,
  input  logic       sdaBit,
  input  logic       alertActive,
  input  logic [6:0] rxLow7,
  input  logic       bitLast,
  input  logic       txBit,
  output dpCtrlT     dpCtl,
  output logic       sdaPullLow,
  output logic       arbWon,
  output logic       selfAddressed
);

  tgtStateT state, stateN;
  logic rwQ, rwN;
  logic araQ, araN;
  logic dataQ, dataN;
  logic ptrDoneQ, ptrDoneN;
  logic mAckQ, mAckN;
  logic winN, selfN;

  always_comb begin
    stateN   = state;
    rwN      = rwQ;
    araN     = araQ;
    dataN    = dataQ;
    ptrDoneN = ptrDoneQ;
    mAckN    = mAckQ;
    winN     = 1'b0;
    selfN    = 1'b0;
    dpCtl    = '0;
    if (stopDet) begin
      stateN = ST_IDLE;
    end else if (startDet) begin
      stateN       = ST_RX_ADDR;
      dpCtl.bitClr = 1'b1;
      dataN        = 1'b0;
      araN         = 1'b0;
    end else begin
      unique case (state)
        ST_RX_ADDR: if (sclRise) begin
          dpCtl.rxShift = 1'b1;
          if (bitLast) begin
            if (rxLow7 == OWN_ADDR) begin
              stateN   = ST_ACK_PEND;
              rwN      = sdaBit;
              selfN    = 1'b1;
              ptrDoneN = 1'b0;
            end else if (rxLow7 == ALERT_RESP_ADDR && sdaBit && alertActive) begin
              stateN = ST_ACK_PEND;
              rwN    = 1'b1;
              araN   = 1'b1;
            end else begin
              stateN = ST_WAIT_END;
            end
          end
        end
        ST_RX_DATA: if (sclRise) begin
          dpCtl.rxShift = 1'b1;
          if (bitLast) stateN = ST_ACK_PEND;
        end
        ST_ACK_PEND: if (sclFall) begin
          stateN = ST_ACK_DRIVE;
          if (dataQ) begin
            if (!ptrDoneQ) begin
              dpCtl.ptrLoad = 1'b1;
              ptrDoneN      = 1'b1;
            end else begin
              dpCtl.regLoad = 1'b1;
            end
          end
        end
        ST_ACK_DRIVE: if (sclFall) begin
          dpCtl.bitClr = 1'b1;
          if (!dataQ && rwQ) begin
            stateN = ST_TX_BYTE;
            if (araQ) dpCtl.txLoadAra = 1'b1;
            else      dpCtl.txLoadReg = 1'b1;
          end else begin
            stateN = ST_RX_DATA;
            dataN  = 1'b1;
          end
        end
        ST_TX_BYTE: begin
          if (sclRise && araQ && txBit && !sdaBit) begin
            stateN = ST_WAIT_END;          // lost arbitration
          end else if (sclFall) begin
            if (bitLast) begin
              stateN = ST_MACK;
              winN   = araQ;
            end else begin
              dpCtl.txShift = 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) mAckN = !sdaBit;
          if (sclFall) begin
            if (mAckQ && !araQ) begin
              stateN          = ST_TX_BYTE;
              dpCtl.txLoadReg = 1'b1;
              dpCtl.bitClr    = 1'b1;
            end else begin
              stateN = ST_WAIT_END;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      rwQ           <= 1'b0;
      araQ          <= 1'b0;
      dataQ         <= 1'b0;
      ptrDoneQ      <= 1'b0;
      mAckQ         <= 1'b0;
      arbWon        <= 1'b0;
      selfAddressed <= 1'b0;
    end else begin
      state         <= stateN;
      rwQ           <= rwN;
      araQ          <= araN;
      dataQ         <= dataN;
      ptrDoneQ      <= ptrDoneN;
      mAckQ         <= mAckN;
      arbWon        <= winN;
      selfAddressed <= selfN;
    end
  end

  assign sdaPullLow = (state == ST_ACK_DRIVE) || (state == ST_TX_BYTE && !txBit);

  p_sda_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (sclLevel && $past(sclLevel)) |-> $stable(sdaPullLow));

  p_win_ara_r8: assert property (@(posedge clk) disable iff (!rstN)
    arbWon |-> (araQ && state == ST_MACK));

  p_self_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    selfAddressed |=> !selfAddressed);

  p_win_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    arbWon |=> !arbWon);

endmodule

// File: rtl/smbus_alert_target.sv
module smbus_alert_target
  import smbus_tgt_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h2A,
  parameter int         PTR_W    = 2,
  parameter int         FILT_LEN = 3,
  parameter logic [7:0] RST_BASE = 8'hA0
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaPullLow,
  input  logic alertActive,
  output logic arbWon,
  output logic selfAddressed
);

  logic sclLevel, sdaBit, sclRise, sclFall, startDet, stopDet;
  logic [6:0] rxLow7;
  logic bitLast, txBit;
  dpCtrlT dpCtl;

  smbus_tgt_pins #(.FILT_LEN(FILT_LEN)) i_pins (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLevel(sclLevel), .sdaBit(sdaBit), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet)
  );

  smbus_tgt_ctrl #(.OWN_ADDR(OWN_ADDR)) i_ctrl (
    .clk(clk), .rstN(rstN), .startDet(startDet), .stopDet(stopDet),
    .sclRise(sclRise), .sclFall(sclFall), .sclLevel(sclLevel),
    .sdaBit(sdaBit), .alertActive(alertActive), .rxLow7(rxLow7),
    .bitLast(bitLast), .txBit(txBit), .dpCtl(dpCtl),
    .sdaPullLow(sdaPullLow), .arbWon(arbWon), .selfAddressed(selfAddressed)
  );

  smbus_tgt_dp #(.OWN_ADDR(OWN_ADDR), .PTR_W(PTR_W), .RST_BASE(RST_BASE)) i_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .sdaBit(sdaBit),
    .rxLow7(rxLow7), .bitLast(bitLast), .txBit(txBit)
  );

endmodule

// File: tb/test_smbus_alert_target.sv
module test_smbus_alert_target;

  localparam logic [6:0] OWN = 7'h2A;
  localparam logic [6:0] ARA = 7'b0001100;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, rivalPull = 1'b0, alertActive = 1'b0;
  logic rivalOn = 1'b0;
  logic [7:0] rivalByte = 8'hFF;
  wire sdaPullLow, arbWon, selfAddressed;
  wire sdaBus = sdaM & ~sdaPullLow & ~rivalPull;

  smbus_alert_target i_smbus_alert_target (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaPullLow(sdaPullLow), .alertActive(alertActive),
    .arbWon(arbWon), .selfAddressed(selfAddressed)
  );

  int checks = 0, errors = 0;
  int selfCnt = 0, arbCnt = 0, expSelf = 0, expArb = 0, holdErr = 0;
  logic prevDrive = 1'b0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (selfAddressed) selfCnt++;
    if (arbWon) arbCnt++;
    if (rstN && sclM && sdaPullLow !== prevDrive) holdErr++;
    prevDrive = sdaPullLow;
  end

  // scoreboard
  logic [7:0] expQ[$];
  string reqQ[$];
  logic [7:0] rxVal;
  event rxEv;

  task automatic expectByte(input logic [7:0] v, input string req);
    expQ.push_back(v);
    reqQ.push_back(req);
  endtask

  initial forever begin
    @rxEv;
    if (expQ.size() == 0) chk("scoreboard empty", rxVal, 8'hxx);
    else chk(reqQ.pop_front(), rxVal, expQ.pop_front());
  end

  task automatic q();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic busStart();
    sdaM = 1'b1; sclM = 1'b1; q(); sdaM = 1'b0; q(); sclM = 1'b0;
  endtask

  task automatic busRestart();
    q(); sdaM = 1'b1; q(); sclM = 1'b1; q(); sdaM = 1'b0; q(); sclM = 1'b0;
  endtask

  task automatic busStop();
    q(); sdaM = 1'b0; q(); sclM = 1'b1; q(); sdaM = 1'b1; q(); q();
  endtask

  task automatic writeBit(input logic b);
    q(); sdaM = b; rivalPull = 1'b0; q(); sclM = 1'b1; q(); q(); sclM = 1'b0;
  endtask

  task automatic readBit(output logic b);
    q(); sdaM = 1'b1; rivalPull = rivalOn && !rivalByte[7];
    q(); sclM = 1'b1; q(); b = sdaBus;
    if (rivalOn && rivalByte[7] && !b) rivalOn = 1'b0;
    rivalByte = {rivalByte[6:0], 1'b1};
    q(); sclM = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(b);
    ack = !b;
  endtask

  task automatic readByte(input logic ackIt);
    logic b;
    logic [7:0] v;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      readBit(b);
      v = {v[6:0], b};
    end
    rivalOn = 1'b0; rivalPull = 1'b0;
    writeBit(!ackIt);
    rxVal = v;
    ->rxEv;
  endtask

  task automatic addrOwn(input logic rd, input string req);
    logic a;
    writeByte({OWN, rd}, a);
    chk(req, {7'd0, a}, 8'd1);
    expSelf++;
  endtask

  task automatic dataOut(input logic [7:0] v, input string req);
    logic a;
    writeByte(v, a);
    chk(req, {7'd0, a}, 8'd1);
  endtask

  initial begin
    logic a;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    q();
    chk("R1 sda released", {7'd0, sdaPullLow}, 8'd0);
    chk("R1 arbWon low", {7'd0, arbWon}, 8'd0);
    chk("R1 selfAddressed low", {7'd0, selfAddressed}, 8'd0);

    // R1/R2: Receive Byte after reset returns reg0
    busStart(); addrOwn(1'b1, "R2 read addr ack");
    expectByte(8'hA0, "R1 reset pointer reg0");
    readByte(1'b0); busStop();

    // R3: Write Byte to reg2
    busStart(); addrOwn(1'b0, "R2 write addr ack");
    dataOut(8'h02, "R3 pointer ack"); dataOut(8'h3C, "R3 data ack"); busStop();

    // R5: Read Byte with repeated start
    busStart(); addrOwn(1'b0, "R5 addr");
    dataOut(8'h02, "R5 pointer ack");
    busRestart(); addrOwn(1'b1, "R5 read addr");
    expectByte(8'h3C, "R5 read byte");
    readByte(1'b0);
    q();
    chk("R5 release after nack", {7'd0, sdaBus}, 8'd1);
    busStop();

    // R4: pointer persists, twice
    for (int k = 0; k < 2; k++) begin
      busStart(); addrOwn(1'b1, "R4 addr");
      expectByte(8'h3C, "R4 receive byte");
      readByte(1'b0); busStop();
    end

    // R5: Read Word repeats reg1
    busStart(); addrOwn(1'b0, "R5 addr");
    dataOut(8'h01, "R5 pointer ack");
    busRestart(); addrOwn(1'b1, "R5 read addr");
    expectByte(8'hA1, "R5 word byte0");
    expectByte(8'hA1, "R5 word byte1 repeat");
    readByte(1'b1); readByte(1'b0); busStop();

    // R11: upper pointer bits ignored
    busStart(); addrOwn(1'b0, "R11 addr");
    dataOut(8'h06, "R11 pointer ack"); dataOut(8'h77, "R11 data ack"); busStop();
    busStart(); addrOwn(1'b0, "R11 addr");
    dataOut(8'h02, "R11 pointer ack");
    busRestart(); addrOwn(1'b1, "R11 read addr");
    expectByte(8'h77, "R11 reg2 via pointer 6");
    readByte(1'b0); busStop();

    // R6: foreign address
    busStart(); writeByte({7'h2B, 1'b1}, a); busStop();
    chk("R6 foreign no ack", {7'd0, a}, 8'd0);
    chk("R10 self count", 8'(selfCnt), 8'(expSelf));

    // R7: alert response address rules
    alertActive = 1'b0;
    busStart(); writeByte({ARA, 1'b1}, a); busStop();
    chk("R7 no ack without alert", {7'd0, a}, 8'd0);
    alertActive = 1'b1;
    busStart(); writeByte({ARA, 1'b0}, a); busStop();
    chk("R7 no ack with write bit", {7'd0, a}, 8'd0);

    // R8: alert response alone
    busStart(); writeByte({ARA, 1'b1}, a);
    chk("R7 ack with alert", {7'd0, a}, 8'd1);
    expectByte({OWN, 1'b1}, "R8 response byte");
    readByte(1'b0); busStop();
    expArb++;
    chk("R8 arbWon count", 8'(arbCnt), 8'(expArb));

    // R9: lower rival wins
    busStart(); writeByte({ARA, 1'b1}, a);
    rivalByte = {7'h11, 1'b1}; rivalOn = 1'b1;
    expectByte({7'h11, 1'b1}, "R9 lower rival byte");
    readByte(1'b0); busStop();
    chk("R9 no arbWon on loss", 8'(arbCnt), 8'(expArb));

    // R8/R9: higher rival loses
    busStart(); writeByte({ARA, 1'b1}, a);
    rivalByte = {7'h55, 1'b1}; rivalOn = 1'b1;
    expectByte({OWN, 1'b1}, "R9 higher rival loses");
    readByte(1'b0); busStop();
    expArb++;
    chk("R8 arbWon after win", 8'(arbCnt), 8'(expArb));

    chk("R10 no self pulse for alert response", 8'(selfCnt), 8'(expSelf));
    chk("R12 drive changed with SCL high", 8'(holdErr), 8'd0);
    chk("scoreboard drained", 8'(expQ.size()), 8'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule